// File: doc/BRIEF.md
# Hard-Block Isolation Activity Monitor

This block runs in the programmable fabric and watches for evidence that a hard subsystem which should stay disabled has come alive. It observes three independent signals. The first is the subsystem's reset-acknowledge line, which stays low while the subsystem is held in reset. The second is a bank of output lines that the subsystem's processor would drive if it ever ran code. The third is the status line of the device controller, which reads 1 while that controller is suspended.

Every input passes through a two-flop synchronizer. A configurable settle period after reset masks the start-up states. After that period, any violation sets a sticky bit in a 3-bit cause vector, and the alarm output is the OR of that vector. Static inputs set the expected state of each path and switch each check on or off. A clear input drops only those cause bits whose condition is no longer present.

Top module: `iso_activity_monitor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `alarm` is 0 and `cause` is 3'b000.
- R2: During the first SETTLE clock cycles after reset release, no cause bit is set, whatever the monitored inputs do. Inputs that are quiet again before the period ends leave `cause` at 0.
- R3: With `expect_iso`=1 and `en_ack`=1 after the settle period, a high level on `rst_ack_in` sets `cause[0]`.
- R4: With `en_gpio`=1 after the settle period, any change of any bit of `gpio_in` between consecutive synchronized samples sets `cause[1]`. A single-bit change is enough.
- R5: With `expect_susp`=1 and `en_susp`=1 after the settle period, `sc_status_in`=0 (not suspended) sets `cause[2]`. A value of 1 raises nothing.
- R6: With `expect_iso`=0, a high `rst_ack_in` raises nothing. With `expect_susp`=0, a low `sc_status_in` raises nothing.
- R7: When `en_ack`, `en_gpio` or `en_susp` is 0, the matching path never sets its cause bit.
- R8: A set cause bit stays set after its condition goes away, until `clr` is applied.
- R9: A one-cycle `clr` clears a cause bit only if that bit's condition is absent in that cycle. A bit whose condition is still present stays set.
- R10: `alarm` is 1 exactly when at least one cause bit is 1. Several paths can be flagged at the same time.
- R11: A change on a monitored input is first visible on `cause` after the third rising clock edge that follows it. It is not visible after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_ack_in | input | 1 | Subsystem reset-acknowledge; low while held in reset |
| gpio_in | input | GPIO_W | Processor-driven output lines under watch |
| sc_status_in | input | 1 | Controller status; 1 = suspended |
| expect_iso | input | 1 | Static: subsystem is expected to be in reset |
| expect_susp | input | 1 | Static: controller is expected to be suspended |
| en_ack | input | 1 | Enable for the reset-acknowledge check |
| en_gpio | input | 1 | Enable for the output-line activity check |
| en_susp | input | 1 | Enable for the suspend-status check |
| clr | input | 1 | Request to clear cause bits whose condition is gone |
| alarm | output | 1 | Sticky alarm; OR of the cause bits |
| cause | output | 3 | Sticky causes: [0] reset-ack, [1] line activity, [2] not suspended |

## Verification
A change applied at a falling edge passes two synchronizer stages and then the cause register. It therefore shows on `cause` and `alarm` after the third rising edge. The bench drives all inputs at falling edges and samples two falling edges later to confirm that nothing has changed yet. It samples again one falling edge later to confirm the flag. A clear registers on the single rising edge where `clr` is high, so its effect is checked at the next falling edge. Before a clear, the bench waits three cycles after removing a condition so that the synchronized copy is quiet.

// File: rtl/iso_activity_monitor.sv
module iso_activity_monitor #(
  parameter int GPIO_W = 8,
  parameter int SETTLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_ack_in,
  input  logic [GPIO_W-1:0] gpio_in,
  input  logic              sc_status_in,
  input  logic              expect_iso,
  input  logic              expect_susp,
  input  logic              en_ack,
  input  logic              en_gpio,
  input  logic              en_susp,
  input  logic              clr,
  output logic              alarm,
  output logic [2:0]        cause
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] SETTLE_C = CW'(SETTLE);

  logic [1:0]        ack_sy, st_sy;
  logic [GPIO_W-1:0] g1, g2, gp;
  logic [CW-1:0]     cnt;
  logic              armed;
  logic [2:0]        hit, cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_sy <= 2'b00;
      st_sy  <= 2'b11;
      g1     <= '0;
      g2     <= '0;
      gp     <= '0;
    end else begin
      ack_sy <= {ack_sy[0], rst_ack_in};
      st_sy  <= {st_sy[0], sc_status_in};
      g1     <= gpio_in;
      g2     <= g1;
      gp     <= g2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!armed) cnt <= cnt + CW'(1);
  end

  assign armed = (cnt == SETTLE_C);

  assign hit[0] = en_ack  & expect_iso  &  ack_sy[1];
  assign hit[1] = en_gpio & (g2 != gp);
  assign hit[2] = en_susp & expect_susp & ~st_sy[1];

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= 3'b000;
    else        cause_q <= (armed ? hit : 3'b000) | (clr ? 3'b000 : cause_q);
  end

  assign cause = cause_q;
  assign alarm = |cause_q;
endmodule

module iso_activity_monitor_chk #(
  parameter int GPIO_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              armed,
  input logic              ack_s,
  input logic              st_s,
  input logic [GPIO_W-1:0] g_now,
  input logic [GPIO_W-1:0] g_prev,
  input logic              expect_iso,
  input logic              expect_susp,
  input logic              en_ack,
  input logic              en_gpio,
  input logic              en_susp,
  input logic              clr,
  input logic [2:0]        cause
);
  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> cause == 3'b000); // R2
  AST_ACK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && en_ack && expect_iso && ack_s) |=> cause[0]); // R3
  AST_GPIO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && en_gpio && (g_now != g_prev)) |=> cause[1]); // R4
  AST_SUSP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && en_susp && expect_susp && !st_s) |=> cause[2]); // R5
  AST_ACK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_ack && !clr) |=> $stable(cause[0])); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((cause & $past(cause)) == $past(cause))); // R8
endmodule

bind iso_activity_monitor iso_activity_monitor_chk #(.GPIO_W(GPIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .ack_s(ack_sy[1]), .st_s(st_sy[1]),
  .g_now(g2), .g_prev(gp), .expect_iso(expect_iso), .expect_susp(expect_susp),
  .en_ack(en_ack), .en_gpio(en_gpio), .en_susp(en_susp), .clr(clr), .cause(cause)
);

// File: tb/sim_iso_activity_monitor.sv
`timescale 1ns/1ps
module sim_iso_activity_monitor;
  localparam int GW = 8;
  localparam int ST = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack = 1'b0, st = 1'b1, clr = 1'b0;
  logic [GW-1:0] gpio = '0;
  logic xi = 1'b1, xs = 1'b1, ea = 1'b1, eg = 1'b1, es = 1'b1;
  logic alarm;
  logic [2:0] cause;
  int checks = 0, errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  iso_activity_monitor #(.GPIO_W(GW), .SETTLE(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_ack_in(ack), .gpio_in(gpio), .sc_status_in(st),
    .expect_iso(xi), .expect_susp(xs), .en_ack(ea), .en_gpio(eg), .en_susp(es),
    .clr(clr), .alarm(alarm), .cause(cause));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_clr();
    clr = 1'b1; cyc(1); clr = 1'b0;
  endtask

  task automatic do_reset(input int hold_after);
    rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(hold_after);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cyc(3);
    chk("R1 cause in reset", cause, 3'b000);
    chk("R1 alarm in reset", alarm, 1'b0);
    rst_n = 1'b1; cyc(1);
    chk("R1 cause after release", cause, 3'b000);
    chk("R1 alarm after release", alarm, 1'b0);
  endtask

  task automatic t_settle();
    ack = 1'b1; st = 1'b0;
    for (int i = 0; i < 5; i++) begin gpio = ~gpio; cyc(1); end
    ack = 1'b0; st = 1'b1;
    cyc(ST + 10);
    chk("R2 settle masks start-up", cause, 3'b000);
    chk("R2 alarm quiet", alarm, 1'b0);
  endtask

  task automatic t_ack();
    ack = 1'b1; cyc(2);
    chk("R11 ack not yet visible", cause, 3'b000);
    cyc(1);
    chk("R3 ack flagged", cause, 3'b001);
    chk("R10 alarm on ack", alarm, 1'b1);
    ack = 1'b0; cyc(5);
    chk("R8 ack sticky", cause, 3'b001);
    pulse_clr();
    chk("R9 clear after removal", cause, 3'b000);
    chk("R10 alarm cleared", alarm, 1'b0);
  endtask

  task automatic t_clr_blocked();
    ack = 1'b1; cyc(4);
    pulse_clr();
    chk("R9 clear blocked while present", cause, 3'b001);
    ack = 1'b0; cyc(4);
    pulse_clr();
    chk("R9 clear once absent", cause, 3'b000);
  endtask

  task automatic t_gpio();
    gpio = 8'h5A; cyc(2);
    chk("R11 gpio not yet visible", cause, 3'b000);
    cyc(1);
    chk("R4 gpio activity flagged", cause, 3'b010);
    cyc(4); pulse_clr();
    chk("R9 gpio cleared", cause, 3'b000);
    gpio = 8'hDA; cyc(3);
    chk("R4 single-bit change", cause, 3'b010);
    cyc(4); pulse_clr();
    chk("R9 gpio cleared again", cause, 3'b000);
  endtask

  task automatic t_susp();
    cyc(6);
    chk("R5 suspended raises nothing", cause, 3'b000);
    st = 1'b0; cyc(3);
    chk("R5 not suspended flagged", cause, 3'b100);
    st = 1'b1; cyc(4); pulse_clr();
    chk("R9 susp cleared", cause, 3'b000);
  endtask

  task automatic t_expect_off();
    xi = 1'b0; xs = 1'b0;
    ack = 1'b1; st = 1'b0; cyc(8);
    chk("R6 expectations off", cause, 3'b000);
    chk("R6 alarm quiet", alarm, 1'b0);
    ack = 1'b0; st = 1'b1; cyc(4);
    xi = 1'b1; xs = 1'b1; cyc(2);
    chk("R6 restored clean", cause, 3'b000);
  endtask

  task automatic t_mask();
    ea = 1'b0; eg = 1'b0; es = 1'b0;
    ack = 1'b1; st = 1'b0;
    for (int i = 0; i < 4; i++) begin gpio = gpio + 8'h11; cyc(1); end
    cyc(4);
    chk("R7 all paths masked", cause, 3'b000);
    ack = 1'b0; st = 1'b1; cyc(4);
    ea = 1'b1; eg = 1'b1; es = 1'b1; cyc(2);
    chk("R7 re-enabled clean", cause, 3'b000);
  endtask

  task automatic t_multi();
    ack = 1'b1; st = 1'b0; cyc(3);
    chk("R10 two causes at once", cause, 3'b101);
    chk("R10 alarm with two causes", alarm, 1'b1);
    ack = 1'b0; cyc(4); pulse_clr();
    chk("R9 partial clear", cause, 3'b100);
    st = 1'b1; cyc(4); pulse_clr();
    chk("R9 full clear", cause, 3'b000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    cyc(1);
    t_reset();
    do_reset(0);
    t_settle();
    t_ack();
    t_clr_blocked();
    t_gpio();
    t_susp();
    t_expect_off();
    t_mask();
    t_multi();
    finish_run();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end
endmodule